// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load Interlock Controller

This block is the hazard control for a five-stage in-order pipeline: fetch, decode with register read, execute, memory access and writeback. Every instruction passes through all five stages. Source registers are read in decode and results are written in writeback. The block gets a short description of the instruction now in decode: its source and destination register numbers, whether it uses each source, and whether it writes a register, loads or stores. It keeps its own shadow of that description for the execute, memory and writeback stages. From these it drives the operand source selects for execute, the stall and bubble request for a load followed by a dependent instruction, a decode read bypass for writes landing in the same cycle, and a memory-stage store-data bypass.

In every cycle the select for each execute operand picks the register file, the result held after execute, or the value held after memory access. When a load sits in execute and the instruction in decode needs the loaded register as an ALU operand, the block raises `stall_o` for one cycle. The surrounding pipeline then holds the program counter and the fetch/decode latch. The block itself loads an all-zero entry, a bubble, into its execute shadow. A store whose data register was loaded by the instruction directly ahead of it is not stalled. Its data is taken from the writeback latch while the store is in the memory stage.

Top module: `fwd_stall_unit`

## Requirements
- R1: After reset all outputs are 0: no stall, both operand selects 2'b00 (register file), and all bypass flags low.
- R2: An execute operand that is used and whose nonzero register number equals the destination of a register-writing, non-load instruction in the memory stage gets select 2'b01.
- R3: Otherwise, an execute operand that is used and whose nonzero register number equals the destination of a register-writing instruction in the writeback stage gets select 2'b10. In every other case the select is 2'b00.
- R4: When both the memory-stage and writeback-stage instructions write the operand's register, the memory-stage (younger) result wins, giving select 2'b01.
- R5: A producer whose destination is register 0, or that writes no register, never causes forwarding or a stall. Select value 2'b11 never appears.
- R6: `stall_o` is 1 in a cycle exactly when decode holds a valid instruction, a register-writing load with nonzero destination is in execute, and decode uses that register as its first source or as a non-store second source. A stall never lasts two cycles in a row.
- R7: During a stall the execute shadow is loaded with a bubble. In the next cycle both operand selects are 2'b00, and the bubble later forwards nothing.
- R8: A store whose data (second) source equals the destination of a load directly ahead of it is not stalled. `st_data_byp_o` is 1 while that store is in the memory stage and the load is in writeback.
- R9: `id_wb_byp_a_o` / `id_wb_byp_b_o` are 1 when decode is valid, uses that source, and the writeback-stage instruction writes the same nonzero register.
- R10: With `id_valid_i` low, decode raises no stall and no decode bypass, and a bubble enters the execute shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| id_valid_i | input | 1 | Decode holds a real instruction |
| id_rs1_i | input | REG_AW | First source register number |
| id_rs2_i | input | REG_AW | Second source register number (store data for stores) |
| id_use_rs1_i | input | 1 | First source is read |
| id_use_rs2_i | input | 1 | Second source is read |
| id_rd_i | input | REG_AW | Destination register number |
| id_wen_i | input | 1 | Instruction writes a register |
| id_load_i | input | 1 | Instruction is a load |
| id_store_i | input | 1 | Instruction is a store |
| stall_o | output | 1 | Hold PC and fetch/decode latch; bubble goes to execute |
| fwd_a_sel_o | output | 2 | First execute operand source: 00 file, 01 memory stage, 10 writeback |
| fwd_b_sel_o | output | 2 | Second execute operand source, same encoding |
| id_wb_byp_a_o | output | 1 | Decode first source takes the writeback value |
| id_wb_byp_b_o | output | 1 | Decode second source takes the writeback value |
| st_data_byp_o | output | 1 | Memory-stage store data takes the writeback load value |

## Verification
The bench builds the block with four registers, so register numbers are two bits and register 0 is one of only four choices. That makes it cheap to sweep every producer kind (ALU write, load, no write) and every destination against every consumer kind and both source numbers, at zero, one and two intervening empty slots. Those distances reach the memory-stage, writeback-stage and decode-bypass windows as well as the interlock. A long pseudo-random stream over the same four registers then produces back-to-back writers of one register, loads feeding stores, and idle decode slots. Expected outputs come from an instruction history kept in the bench.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_EXM = 2'b01,
        SRC_MWB = 2'b10
    } fsu_src_e;

endpackage

// File: rtl/fsu_fwd_pick.sv
module fsu_fwd_pick
    import fsu_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              use_i,
    input  logic [REG_AW-1:0] rs_i,
    input  logic              exm_wen_i,
    input  logic              exm_load_i,
    input  logic [REG_AW-1:0] exm_rd_i,
    input  logic              mwb_wen_i,
    input  logic [REG_AW-1:0] mwb_rd_i,
    output fsu_src_e          sel_o
);
    logic rs_live;
    logic hit_exm;
    logic hit_mwb;

    always_comb begin
        rs_live = use_i && (rs_i != '0);
        // a load in the memory stage has no data yet, so it never feeds execute
        hit_exm = rs_live && exm_wen_i && !exm_load_i && (exm_rd_i == rs_i);
        hit_mwb = rs_live && mwb_wen_i && (mwb_rd_i == rs_i);
        if (hit_exm) begin
            sel_o = SRC_EXM;
        end else if (hit_mwb) begin
            sel_o = SRC_MWB;
        end else begin
            sel_o = SRC_RF;
        end
    end

endmodule

// File: rtl/fsu_load_use.sv
module fsu_load_use #(
    parameter int REG_AW = 5
) (
    input  logic              id_valid_i,
    input  logic              id_store_i,
    input  logic              id_use1_i,
    input  logic              id_use2_i,
    input  logic [REG_AW-1:0] id_rs1_i,
    input  logic [REG_AW-1:0] id_rs2_i,
    input  logic              ex_load_i,
    input  logic              ex_wen_i,
    input  logic [REG_AW-1:0] ex_rd_i,
    output logic              stall_o
);
    logic load_live;
    logic dep1;
    logic dep2;

    always_comb begin
        load_live = ex_load_i && ex_wen_i && (ex_rd_i != '0);
        dep1      = id_use1_i && (id_rs1_i == ex_rd_i);
        // store data is patched in the memory stage instead of waiting
        dep2      = id_use2_i && !id_store_i && (id_rs2_i == ex_rd_i);
        stall_o   = id_valid_i && load_live && (dep1 || dep2);
    end

endmodule

// File: rtl/fsu_wb_bypass.sv
module fsu_wb_bypass #(
    parameter int REG_AW = 5
) (
    input  logic              id_valid_i,
    input  logic              use_i,
    input  logic [REG_AW-1:0] rs_i,
    input  logic              wb_wen_i,
    input  logic [REG_AW-1:0] wb_rd_i,
    output logic              byp_o
);
    always_comb begin
        byp_o = id_valid_i && use_i && wb_wen_i && (wb_rd_i != '0) && (wb_rd_i == rs_i);
    end

endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
    import fsu_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int REG_AW  = $clog2(NUM_REGS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              id_valid_i,
    input  logic [REG_AW-1:0] id_rs1_i,
    input  logic [REG_AW-1:0] id_rs2_i,
    input  logic              id_use_rs1_i,
    input  logic              id_use_rs2_i,
    input  logic [REG_AW-1:0] id_rd_i,
    input  logic              id_wen_i,
    input  logic              id_load_i,
    input  logic              id_store_i,
    output logic              stall_o,
    output logic [1:0]        fwd_a_sel_o,
    output logic [1:0]        fwd_b_sel_o,
    output logic              id_wb_byp_a_o,
    output logic              id_wb_byp_b_o,
    output logic              st_data_byp_o
);
    localparam int N_SRC = 2;

    typedef struct packed {
        logic              wen;
        logic              load;
        logic              store;
        logic              use1;
        logic              use2;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rs1;
        logic [REG_AW-1:0] rs2;
    } slot_t;

    typedef struct packed {
        slot_t ex;
        slot_t mem;
        slot_t wb;
    } shadow_t;

    shadow_t sh_d, sh_q;
    logic    stall;

    logic [REG_AW-1:0] ex_rs   [N_SRC];
    logic              ex_use  [N_SRC];
    logic [REG_AW-1:0] id_rs   [N_SRC];
    logic              id_use  [N_SRC];
    fsu_src_e          src_sel [N_SRC];
    logic              id_byp  [N_SRC];

    always_comb begin
        ex_rs[0]  = sh_q.ex.rs1;
        ex_rs[1]  = sh_q.ex.rs2;
        ex_use[0] = sh_q.ex.use1;
        ex_use[1] = sh_q.ex.use2;
        id_rs[0]  = id_rs1_i;
        id_rs[1]  = id_rs2_i;
        id_use[0] = id_use_rs1_i;
        id_use[1] = id_use_rs2_i;
    end

    fsu_load_use #(.REG_AW(REG_AW)) i_load_use (
        .id_valid_i (id_valid_i),
        .id_store_i (id_store_i),
        .id_use1_i  (id_use_rs1_i),
        .id_use2_i  (id_use_rs2_i),
        .id_rs1_i   (id_rs1_i),
        .id_rs2_i   (id_rs2_i),
        .ex_load_i  (sh_q.ex.load),
        .ex_wen_i   (sh_q.ex.wen),
        .ex_rd_i    (sh_q.ex.rd),
        .stall_o    (stall)
    );

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        fsu_fwd_pick #(.REG_AW(REG_AW)) i_pick (
            .use_i      (ex_use[s]),
            .rs_i       (ex_rs[s]),
            .exm_wen_i  (sh_q.mem.wen),
            .exm_load_i (sh_q.mem.load),
            .exm_rd_i   (sh_q.mem.rd),
            .mwb_wen_i  (sh_q.wb.wen),
            .mwb_rd_i   (sh_q.wb.rd),
            .sel_o      (src_sel[s])
        );

        fsu_wb_bypass #(.REG_AW(REG_AW)) i_wbb (
            .id_valid_i (id_valid_i),
            .use_i      (id_use[s]),
            .rs_i       (id_rs[s]),
            .wb_wen_i   (sh_q.wb.wen),
            .wb_rd_i    (sh_q.wb.rd),
            .byp_o      (id_byp[s])
        );
    end

    // next-state: shadow advances every cycle; a stall or idle decode yields a bubble
    always_comb begin
        sh_d     = sh_q;
        sh_d.wb  = sh_q.mem;
        sh_d.mem = sh_q.ex;
        if (stall || !id_valid_i) begin
            sh_d.ex = '0;
        end else begin
            sh_d.ex.wen   = id_wen_i;
            sh_d.ex.load  = id_load_i;
            sh_d.ex.store = id_store_i;
            sh_d.ex.use1  = id_use_rs1_i;
            sh_d.ex.use2  = id_use_rs2_i;
            sh_d.ex.rd    = id_rd_i;
            sh_d.ex.rs1   = id_rs1_i;
            sh_d.ex.rs2   = id_rs2_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    always_comb begin
        stall_o       = stall;
        fwd_a_sel_o   = src_sel[0];
        fwd_b_sel_o   = src_sel[1];
        id_wb_byp_a_o = id_byp[0];
        id_wb_byp_b_o = id_byp[1];
        st_data_byp_o = sh_q.mem.store && sh_q.mem.use2 && sh_q.wb.load && sh_q.wb.wen
                        && (sh_q.wb.rd != '0) && (sh_q.wb.rd == sh_q.mem.rs2);
    end

endmodule

// File: rtl/fsu_checker.sv
module fsu_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       id_valid_i,
    input logic       stall_o,
    input logic [1:0] fwd_a_sel_o,
    input logic [1:0] fwd_b_sel_o,
    input logic       id_wb_byp_a_o,
    input logic       id_wb_byp_b_o,
    input logic       st_data_byp_o
);
    p_stall_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |=> !stall_o);

    p_bubble_reads_file_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |=> (fwd_a_sel_o == 2'b00 && fwd_b_sel_o == 2'b00));

    p_sel_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fwd_a_sel_o != 2'b11) && (fwd_b_sel_o != 2'b11));

    p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !id_valid_i |-> (!stall_o && !id_wb_byp_a_o && !id_wb_byp_b_o));

    p_store_patch_after_issue_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_data_byp_o |=> !st_data_byp_o);

endmodule

bind fwd_stall_unit fsu_checker i_fsu_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .id_valid_i    (id_valid_i),
    .stall_o       (stall_o),
    .fwd_a_sel_o   (fwd_a_sel_o),
    .fwd_b_sel_o   (fwd_b_sel_o),
    .id_wb_byp_a_o (id_wb_byp_a_o),
    .id_wb_byp_b_o (id_wb_byp_b_o),
    .st_data_byp_o (st_data_byp_o)
);

// File: tb/test_fwd_stall_unit.sv
module test_fwd_stall_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 4;
    localparam int AW         = $clog2(NREG);
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic          valid;
        logic          wen;
        logic          load;
        logic          store;
        logic          use1;
        logic          use2;
        logic [AW-1:0] rd;
        logic [AW-1:0] rs1;
        logic [AW-1:0] rs2;
    } ins_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          id_valid = 1'b0;
    logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
    logic          id_use1 = 1'b0, id_use2 = 1'b0, id_wen = 1'b0, id_load = 1'b0, id_store = 1'b0;
    logic          stall, wbb_a, wbb_b, st_byp;
    logic [1:0]    sel_a, sel_b;

    int   n_vec  = 0;
    int   n_fail = 0;
    int   cycles = 0;
    ins_t m_ex = '0, m_mem = '0, m_wb = '0;
    logic last_stall;
    logic [31:0] lfsr = 32'h1ace_b00c;

    fwd_stall_unit #(.NUM_REGS(NREG)) i_fwd_stall_unit (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .id_valid_i    (id_valid),
        .id_rs1_i      (id_rs1),
        .id_rs2_i      (id_rs2),
        .id_use_rs1_i  (id_use1),
        .id_use_rs2_i  (id_use2),
        .id_rd_i       (id_rd),
        .id_wen_i      (id_wen),
        .id_load_i     (id_load),
        .id_store_i    (id_store),
        .stall_o       (stall),
        .fwd_a_sel_o   (sel_a),
        .fwd_b_sel_o   (sel_b),
        .id_wb_byp_a_o (wbb_a),
        .id_wb_byp_b_o (wbb_b),
        .st_data_byp_o (st_byp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    // R2 R3 R4 R5: source select from the youngest live writer
    function automatic logic [1:0] exp_sel(input logic u, input logic [AW-1:0] rs);
        if (u && rs != 0 && m_mem.wen && !m_mem.load && m_mem.rd == rs) return 2'b01;
        if (u && rs != 0 && m_wb.wen && m_wb.rd == rs) return 2'b10;
        return 2'b00;
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one cycle: check at negedge, advance model at posedge
    task automatic step();
        logic e_stall, e_wa, e_wb, e_st;
        @(negedge clk);
        e_stall = id_valid && m_ex.load && m_ex.wen && m_ex.rd != 0 &&
                  ((id_use1 && id_rs1 == m_ex.rd) || (id_use2 && !id_store && id_rs2 == m_ex.rd));
        e_wa = id_valid && id_use1 && m_wb.wen && m_wb.rd != 0 && m_wb.rd == id_rs1;
        e_wb = id_valid && id_use2 && m_wb.wen && m_wb.rd != 0 && m_wb.rd == id_rs2;
        e_st = m_mem.store && m_mem.use2 && m_wb.load && m_wb.wen && m_wb.rd != 0 && m_wb.rd == m_mem.rs2;
        n_vec = n_vec + 1;
        cmp("R6 R8 R10 stall", int'(stall), int'(e_stall));
        cmp("R2 R3 R4 R5 R7 sel_a", int'(sel_a), int'(exp_sel(m_ex.use1, m_ex.rs1)));
        cmp("R2 R3 R4 R5 R7 sel_b", int'(sel_b), int'(exp_sel(m_ex.use2, m_ex.rs2)));
        cmp("R9 wb_byp_a", int'(wbb_a), int'(e_wa));
        cmp("R9 wb_byp_b", int'(wbb_b), int'(e_wb));
        cmp("R8 st_byp", int'(st_byp), int'(e_st));
        @(posedge clk);
        m_wb  = m_mem;
        m_mem = m_ex;
        if (e_stall || !id_valid) m_ex = '0;
        else m_ex = '{1'b1, id_wen, id_load, id_store, id_use1, id_use2, id_rd, id_rs1, id_rs2};
        last_stall = e_stall;
        #1;
    endtask

    task automatic issue(input ins_t x);
        id_valid = x.valid; id_wen = x.wen; id_load = x.load; id_store = x.store;
        id_use1 = x.use1; id_use2 = x.use2; id_rd = x.rd; id_rs1 = x.rs1; id_rs2 = x.rs2;
        step();
        while (last_stall) step();
    endtask

    function automatic ins_t mk(input int kind, input logic [AW-1:0] rd,
                                input logic [AW-1:0] r1, input logic [AW-1:0] r2);
        ins_t x = '0;
        x.valid = 1'b1;
        case (kind)
            0: begin x.wen = 1; x.use1 = 1; x.use2 = 1; end   // ALU writer
            1: begin x.wen = 1; x.load = 1; x.use1 = 1; end   // load
            2: begin x.use1 = 1; end                          // no write
            default: begin x.store = 1; x.use1 = 1; x.use2 = 1; end // store
        endcase
        x.rd = rd; x.rs1 = r1; x.rs2 = r2;
        return x;
    endfunction

    initial begin
        ins_t nop;
        nop = '0; nop.valid = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        @(negedge clk);
        n_vec = n_vec + 1;
        cmp("R1 stall", int'(stall), 0);
        cmp("R1 sel_a", int'(sel_a), 0);
        cmp("R1 sel_b", int'(sel_b), 0);
        cmp("R1 byp", int'({wbb_a, wbb_b, st_byp}), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // sweep: producer kind x dest x consumer kind x sources x distance
        for (int pk = 0; pk < 3; pk++)
            for (int prd = 0; prd < NREG; prd++)
                for (int ck = 0; ck < 2; ck++)
                    for (int a = 0; a < NREG; a++)
                        for (int b = 0; b < NREG; b++)
                            for (int gap = 0; gap < 3; gap++) begin
                                issue(mk(pk, AW'(prd), AW'(a), AW'(b)));
                                for (int g = 0; g < gap; g++) issue(nop);
                                issue(mk(ck == 0 ? 0 : 3, AW'(a ^ 1), AW'(a), AW'(b)));
                                for (int g = 0; g < 3; g++) issue(nop);
                            end

        // stream: back-to-back writers, load/store chains, idle slots (R4 R10)
        for (int i = 0; i < 4000; i++) begin
            ins_t x;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            x = mk(int'(lfsr[3:2]), lfsr[5:4], lfsr[7:6], lfsr[9:8]);
            x.use2 = x.use2 | lfsr[10];
            x.valid = (lfsr[13:11] != 3'b000);
            issue(x);
        end
        for (int g = 0; g < 4; g++) issue(nop);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule